// File: doc/BRIEF.md
# Codec Code-Byte Bus Port

This block is the slave end of an 8-bit byte bus that carries compressed code between an external codec and a code FIFO inside the chip. The codec is always the bus master: it frames every access with an active-low select strobe, at a rate of up to one byte per clock and with no idle cycles required between bytes. A direction input chooses between two modes. In compress mode the block takes each byte the codec writes and pushes it into the FIFO. In decompress mode it puts the FIFO head byte on the bus for each codec read and pops it.

The FIFO is outside the block. The block reaches it through push and pop strobes, a head-byte input and two level inputs (free entries and filled entries). The codec decides whether to start an access two clock periods ahead. That is, the busy level in period P governs an access in period P+2. Because of this the block raises busy while one transfer is still allowed, and it counts every transfer already committed when it works out the remaining headroom.

Top module: `codec_byte_port`

## Requirements
- R1: While reset is low, busy is high and the bus output enable is low. A select strobe seen during reset produces no push afterwards.
- R2: In compress mode (mode_dec = 0), a byte present on cbus_in in a period where cs_n is low appears on push_data with push_en high in the next period. Each accessed byte is pushed exactly once and in order, and push_en stays low after a period with no compress access.
- R3: In compress mode, busy is high in a period exactly when fifo_free, minus the push pending in this period, minus the access in this period, is 1 or less.
- R4: In compress mode, a master that obeys busy with its two-period lookahead never causes a push while fifo_free is 0.
- R5: In decompress mode (mode_dec = 1), during a period with cs_n low, cbus_out carries pop_data and pop_en is high in that same period. The codec therefore receives the FIFO bytes in FIFO order, each byte once.
- R6: In decompress mode, busy is high in a period exactly when fifo_fill, minus the access in this period, is 1 or less.
- R7: In decompress mode, a master that obeys busy never causes a pop while fifo_fill is 0.
- R8: cbus_oe is high only in decompress mode with cs_n low, and it is low in every other period.
- R9: In compress mode pop_en never rises. In decompress mode push_en stays low once the last compress capture has left.
- R10: While busy stays low, the codec may run back-to-back accesses on consecutive clocks, and each one is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; every signal is synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_dec | input | 1 | 0 = compress (codec writes), 1 = decompress (codec reads) |
| cs_n | input | 1 | Active-low access strobe from the codec, one byte per low period |
| cbus_in | input | DATA_W | Byte driven by the codec in compress mode |
| cbus_out | output | DATA_W | Byte driven to the codec in decompress mode |
| cbus_oe | output | 1 | Output enable for cbus_out |
| busy | output | 1 | Throttle; the codec holds off accesses two periods after seeing it high |
| push_en | output | 1 | FIFO push strobe, taken at the clock edge |
| push_data | output | DATA_W | Byte to push |
| fifo_free | input | LVL_W | Free FIFO entries after the last edge |
| pop_en | output | 1 | FIFO pop strobe, taken at the clock edge |
| pop_data | input | DATA_W | Current FIFO head byte |
| fifo_fill | input | LVL_W | Filled FIFO entries after the last edge |

## Verification
The bench plays the codec with its two-period busy lookahead and plays the FIFO with real capacity limits, so a throttle threshold that is one entry short shows up as a push into a full FIFO or a pop from an empty one. A compress run drains the FIFO more slowly than the codec writes, and a decompress run refills it more slowly than the codec reads, so bursts are cut off by busy many times. A design that counted the in-flight capture wrongly would drop, repeat or overflow bytes across those cuts, and the scoreboard would report this. The bench also predicts busy in every period from the level inputs, compares the length of the opening burst, and watches the output enable and the strobe that belongs to the other mode.

// File: rtl/cbp_pkg.sv
`timescale 1ns/1ps
package cbp_pkg;

  typedef enum logic {
    DIR_COMPRESS   = 1'b0,
    DIR_DECOMPRESS = 1'b1
  } dir_e;

  // Headroom left after transfers already committed, compared with the margin
  // the master's lookahead needs.
  function automatic logic hold_needed(input int level, input int committed, input int margin);
    return (level - committed) <= margin;
  endfunction

endpackage

// File: rtl/cbp_capture.sv
`timescale 1ns/1ps
module cbp_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] cbus_in,
  output logic              push_en,
  output logic [DATA_W-1:0] push_data
);

  logic              cap_vld_q;
  logic [DATA_W-1:0] cap_byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld_q  <= 1'b0;
      cap_byte_q <= '0;
    end else begin
      cap_vld_q <= acc_wr;
      if (acc_wr) cap_byte_q <= cbus_in;
    end
  end

  assign push_en   = cap_vld_q;
  assign push_data = cap_byte_q;

endmodule

// File: rtl/cbp_feed.sv
`timescale 1ns/1ps
module cbp_feed #(
  parameter int DATA_W = 8
) (
  input  logic              acc_rd,
  input  logic [DATA_W-1:0] pop_data,
  output logic              pop_en,
  output logic [DATA_W-1:0] cbus_out,
  output logic              cbus_oe
);

  assign pop_en   = acc_rd;
  assign cbus_oe  = acc_rd;
  assign cbus_out = acc_rd ? pop_data : '0;

endmodule

// File: rtl/cbp_throttle.sv
`timescale 1ns/1ps
module cbp_throttle
  import cbp_pkg::*;
#(
  parameter int LVL_W  = 5,
  parameter int MARGIN = 1
) (
  input  logic             rst_n,
  input  dir_e             dir,
  input  logic [LVL_W-1:0] fifo_free,
  input  logic [LVL_W-1:0] fifo_fill,
  input  logic             wr_pend,
  input  logic             acc_wr,
  input  logic             acc_rd,
  output logic             busy
);

  logic room_low;
  logic data_low;

  always_comb begin
    room_low = hold_needed(int'(fifo_free), int'(wr_pend) + int'(acc_wr), MARGIN);
    data_low = hold_needed(int'(fifo_fill), int'(acc_rd), MARGIN);
  end

  assign busy = !rst_n || ((dir == DIR_DECOMPRESS) ? data_low : room_low);

endmodule

// File: rtl/codec_byte_port.sv
`timescale 1ns/1ps
module codec_byte_port
  import cbp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 5,
  parameter int MARGIN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_dec,
  input  logic              cs_n,
  input  logic [DATA_W-1:0] cbus_in,
  output logic [DATA_W-1:0] cbus_out,
  output logic              cbus_oe,
  output logic              busy,
  output logic              push_en,
  output logic [DATA_W-1:0] push_data,
  input  logic [LVL_W-1:0]  fifo_free,
  output logic              pop_en,
  input  logic [DATA_W-1:0] pop_data,
  input  logic [LVL_W-1:0]  fifo_fill
);

  dir_e dir;
  logic acc_cyc;
  logic acc_wr;
  logic acc_rd;

  assign dir     = mode_dec ? DIR_DECOMPRESS : DIR_COMPRESS;
  assign acc_cyc = rst_n && !cs_n;
  assign acc_wr  = acc_cyc && (dir == DIR_COMPRESS);
  assign acc_rd  = acc_cyc && (dir == DIR_DECOMPRESS);

  cbp_capture #(.DATA_W(DATA_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_wr    (acc_wr),
    .cbus_in   (cbus_in),
    .push_en   (push_en),
    .push_data (push_data)
  );

  cbp_feed #(.DATA_W(DATA_W)) u_feed (
    .acc_rd   (acc_rd),
    .pop_data (pop_data),
    .pop_en   (pop_en),
    .cbus_out (cbus_out),
    .cbus_oe  (cbus_oe)
  );

  cbp_throttle #(.LVL_W(LVL_W), .MARGIN(MARGIN)) u_throttle (
    .rst_n     (rst_n),
    .dir       (dir),
    .fifo_free (fifo_free),
    .fifo_fill (fifo_fill),
    .wr_pend   (push_en),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .busy      (busy)
  );

endmodule

// File: rtl/cbp_checker.sv
`timescale 1ns/1ps
module cbp_checker #(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_dec,
  input logic              cs_n,
  input logic [DATA_W-1:0] cbus_in,
  input logic              cbus_oe,
  input logic              busy,
  input logic              push_en,
  input logic [DATA_W-1:0] push_data,
  input logic [LVL_W-1:0]  fifo_free,
  input logic              pop_en,
  input logic [LVL_W-1:0]  fifo_fill
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (busy && !cbus_oe));

  p_push_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !mode_dec) |=> (push_en && push_data == $past(cbus_in)));

  p_push_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || mode_dec) |=> !push_en);

  p_busy_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_dec && fifo_free <= 1) |-> busy);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (fifo_free != 0));

  p_busy_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dec && fifo_fill <= 1) |-> busy);

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (fifo_fill != 0));

  p_oe_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cbus_oe |-> (pop_en && !cs_n && mode_dec));

  p_no_pop_compress_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_dec |-> (!pop_en && !cbus_oe));

endmodule

bind codec_byte_port cbp_checker #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_cbp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_dec  (mode_dec),
  .cs_n      (cs_n),
  .cbus_in   (cbus_in),
  .cbus_oe   (cbus_oe),
  .busy      (busy),
  .push_en   (push_en),
  .push_data (push_data),
  .fifo_free (fifo_free),
  .pop_en    (pop_en),
  .fifo_fill (fifo_fill)
);

// File: tb/codec_byte_port_bench.sv
`timescale 1ns/1ps
module codec_byte_port_bench;

  localparam int DATA_W = 8;
  localparam int LVL_W  = 5;
  localparam int DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_dec = 1'b0;
  logic              cs_n = 1'b1;
  logic [DATA_W-1:0] cbus_in = '0;
  logic [DATA_W-1:0] cbus_out;
  logic              cbus_oe;
  logic              busy;
  logic              push_en;
  logic [DATA_W-1:0] push_data;
  logic [LVL_W-1:0]  fifo_free = LVL_W'(DEPTH);
  logic              pop_en;
  logic [DATA_W-1:0] pop_data = '0;
  logic [LVL_W-1:0]  fifo_fill = '0;

  always #4 clk = ~clk;

  codec_byte_port #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_codec_byte_port (
    .clk(clk), .rst_n(rst_n), .mode_dec(mode_dec), .cs_n(cs_n),
    .cbus_in(cbus_in), .cbus_out(cbus_out), .cbus_oe(cbus_oe), .busy(busy),
    .push_en(push_en), .push_data(push_data), .fifo_free(fifo_free),
    .pop_en(pop_en), .pop_data(pop_data), .fifo_fill(fifo_fill)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [DATA_W-1:0] fq[$];
  logic [DATA_W-1:0] exp_q[$];

  bit b1 = 1'b1, b2 = 1'b1;
  int want_left = 0;
  int prod_left = 0;
  bit cons_on = 1'b0;
  bit mon_on = 1'b0;
  int cyc = 0;
  int ovf = 0, udf = 0;
  int rx_cnt = 0;
  int tx_idx = 0, prod_idx = 0;
  int first_run = 0;
  bit run_open = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic sync_levels();
    fifo_fill = LVL_W'(fq.size());
    fifo_free = LVL_W'(DEPTH - fq.size());
    pop_data  = (fq.size() > 0) ? fq[0] : '0;
  endtask

  // One period of codec master plus FIFO model.
  task automatic step();
    bit pp, po;
    logic [DATA_W-1:0] pd;
    @(negedge clk);
    b2 = b1;
    b1 = busy;
    pp = push_en;
    pd = push_data;
    po = pop_en;
    @(posedge clk);
    #1;
    cyc++;
    if (pp) begin
      if (fq.size() >= DEPTH) ovf++;
      else fq.push_back(pd);
    end
    if (po) begin
      if (fq.size() == 0) udf++;
      else void'(fq.pop_front());
    end
    if (cons_on && (cyc % 3 == 0) && fq.size() > 0) void'(fq.pop_front());
    if (prod_left > 0 && (cyc % 3 == 0) && fq.size() < DEPTH) begin
      logic [DATA_W-1:0] nb;
      nb = DATA_W'(8'hA0 ^ (prod_idx * 3));
      fq.push_back(nb);
      exp_q.push_back(nb);
      prod_idx++;
      prod_left--;
    end
    sync_levels();
    if (want_left > 0 && !b2) begin
      cs_n = 1'b0;
      want_left--;
      if (!mode_dec) begin
        cbus_in = DATA_W'(8'h30 + tx_idx * 7);
        exp_q.push_back(cbus_in);
        tx_idx++;
      end
      if (run_open) first_run++;
    end else begin
      cs_n = 1'b1;
      run_open = 1'b0;
    end
  endtask

  // Monitor: scoreboard compare and per-period rule checks.
  bit prev_wr = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      bit acc;
      int expb;
      acc = !cs_n;
      if (!mode_dec) begin
        expb = ((int'(fifo_free) - int'(prev_wr) - int'(acc)) <= 1) ? 1 : 0;
        chk(busy == expb[0], "R3 busy in compress", int'(busy), expb);
        chk(!pop_en, "R9 pop in compress", int'(pop_en), 0);
        if (push_en) begin
          if (exp_q.size() == 0) chk(1'b0, "R2 unexpected push", int'(push_data), -1);
          else begin
            logic [DATA_W-1:0] e;
            e = exp_q.pop_front();
            chk(push_data == e, "R2 pushed byte", int'(push_data), int'(e));
          end
        end
      end else begin
        expb = ((int'(fifo_fill) - int'(acc)) <= 1) ? 1 : 0;
        chk(busy == expb[0], "R6 busy in decompress", int'(busy), expb);
        chk(!push_en, "R9 push in decompress", int'(push_en), 0);
        if (acc) begin
          chk(pop_en, "R5 pop strobe", int'(pop_en), 1);
          if (exp_q.size() == 0) chk(1'b0, "R5 read with nothing expected", int'(cbus_out), -1);
          else begin
            logic [DATA_W-1:0] e;
            e = exp_q.pop_front();
            chk(cbus_out == e, "R5 read byte", int'(cbus_out), int'(e));
            rx_cnt++;
          end
        end
      end
      chk(cbus_oe == (mode_dec && acc), "R8 output enable", int'(cbus_oe), int'(mode_dec && acc));
      prev_wr = acc && !mode_dec;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with a strobe seen during reset
    repeat (2) @(posedge clk);
    #1 cs_n = 1'b0;
    cbus_in = 8'h5A;
    @(posedge clk);
    #1 cs_n = 1'b1;
    @(negedge clk);
    chk(busy, "R1 busy in reset", int'(busy), 1);
    chk(!cbus_oe, "R1 oe in reset", int'(cbus_oe), 0);
    chk(!pop_en, "R1 pop in reset", int'(pop_en), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!push_en, "R1 no push from reset strobe", int'(push_en), 0);
    chk(!busy, "R1 busy clears with empty FIFO", int'(busy), 0);
    mon_on = 1'b1;
    repeat (3) step();

    // Compress: fast writer, slow drain (R2, R3, R4, R10)
    want_left = 30;
    run_open = 1'b1;
    cons_on = 1'b1;
    while (want_left > 0) step();
    repeat (40) step();
    chk(first_run >= 5, "R10 opening burst length", first_run, 5);
    chk(exp_q.size() == 0, "R2 all bytes pushed", exp_q.size(), 0);
    chk(tx_idx == 30, "R2 bytes sent", tx_idx, 30);
    chk(ovf == 0, "R4 overflow count", ovf, 0);
    chk(fq.size() == 0, "R2 FIFO drained", fq.size(), 0);
    cons_on = 1'b0;
    repeat (4) step();

    // Decompress: preload, fast reader, slow producer (R5, R6, R7)
    mode_dec = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      logic [DATA_W-1:0] nb;
      nb = DATA_W'(8'hA0 ^ (prod_idx * 3));
      fq.push_back(nb);
      exp_q.push_back(nb);
      prod_idx++;
    end
    sync_levels();
    prod_left = 32;
    want_left = 60;
    repeat (200) step();
    want_left = 0;
    repeat (4) step();
    chk(udf == 0, "R7 underflow count", udf, 0);
    chk(rx_cnt >= 39, "R5 bytes read", rx_cnt, 39);
    chk(exp_q.size() <= 1, "R5 bytes left unread", exp_q.size(), 1);
    chk(exp_q.size() == fq.size(), "R5 FIFO and scoreboard agree", fq.size(), exp_q.size());
    chk(ovf == 0, "R4 overflow count end", ovf, 0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule